// File: doc/BRIEF.md
# Thermal Trip Emergency Power-Down Latch

This block turns a processor overheat indication into an immediate and latched power-down of the platform. The active-low trip input passes through a two-flop synchronizer. When one synchronized active sample arrives while platform reset is released, a single state flop sets. That flop drives all three active-low sleep-control lines low together. The block does not wait for any acknowledge from the processor.

In the same cycle the block raises a one-cycle start request to the normal sleep sequencer, so the orderly soft-off flow can run in parallel. It also sets a sticky trip flag that software reads.

The latch clears only when the sequencer reports that soft-off has been reached. If that report never comes, the lines stay low until the block's own reset, which models a power cycle, is applied. While platform reset is low, the trip input has no effect.

Top module: `thermtrip_guard`

## Requirements
- R1: During and after `rst`, the three sleep lines are high (1), `trip_flag` is 0 and `off_req` is 0.
- R2: While `plat_rst_n` is 0, a low on `trip_n` of any length has no effect. The sleep lines stay 1, `trip_flag` stays 0 and `off_req` stays 0.
- R3: With `plat_rst_n` at 1, a fall of `trip_n` drives all three sleep lines to 0 in the same cycle. The lines are still 1 after the second rising edge that follows the fall, and they are 0 after the third.
- R4: `off_req` is 1 for exactly one cycle. That cycle is the one in which the sleep lines first go to 0.
- R5: `trip_flag` becomes 1 in the same cycle that the sleep lines go to 0.
- R6: The sleep lines stay 0 after `trip_n` returns to 1, for as long as `soft_off_done` stays 0.
- R7: A one-cycle pulse on `soft_off_done` while latched returns the sleep lines to 1 on the next edge. After that, trips are again ignored while `plat_rst_n` is 0.
- R8: Without `soft_off_done`, the latch holds for as long as the block runs. Only `rst` clears the latch and `trip_flag`.
- R9: A pulse on `status_clr` clears `trip_flag` only while the block is not latched. While latched, the pulse is ignored. If the pulse falls in the cycle in which the latch sets, the flag is set.
- R10: A `soft_off_done` pulse while the block is not latched changes no output.
- R11: A low on `trip_n` lasting one clock period is enough to latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power cycle) |
| trip_n | input | 1 | Asynchronous active-low processor overheat signal |
| plat_rst_n | input | 1 | Platform reset status; 0 means platform is held in reset |
| soft_off_done | input | 1 | Sleep sequencer reports the soft-off state is reached |
| status_clr | input | 1 | Software write-one-to-clear pulse for the trip flag |
| sleep_l1_n | output | 1 | Active-low sleep-control line 1 |
| sleep_l2_n | output | 1 | Active-low sleep-control line 2 |
| sleep_l3_n | output | 1 | Active-low sleep-control line 3 |
| trip_flag | output | 1 | Sticky indication that a trip was latched |
| off_req | output | 1 | One-cycle start request to the sleep sequencer |

## Verification
Two functions can act on the flag in the same cycle: the latch setting, which sets the flag, and a software clear. To provoke the collision, the bench releases a trip and then counts two edges so that the `status_clr` pulse lands exactly on the latching edge. It judges the result by reading `trip_flag` as 1 together with low sleep lines. A second pair shares a cycle in the normal flow: the sequencer's soft-off report and a still-latched condition. The bench sends the report only after the trip input has been released and flushed through the synchronizer, and it expects the lines to rise on the next edge with the flag kept.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic {
    TT_ARMED   = 1'b0,
    TT_TRIPPED = 1'b1
  } tt_state_e;
endpackage

// File: rtl/tt_sync.sv
module tt_sync #(
  parameter int   STAGES    = 2,
  parameter logic RST_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("tt_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_LEVEL}};
    else     chain <= {chain[LAST-1:0], d};
  end

  assign q = chain[LAST];
endmodule

// File: rtl/tt_trip_latch.sv
module tt_trip_latch
  import tt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic plat_rst_n,
  input  logic trip_act,
  input  logic soft_off,
  output logic tripped,
  output logic hit,
  output logic start_pulse
);
  tt_state_e state;

  assign hit     = (state == TT_ARMED) && plat_rst_n && trip_act;
  assign tripped = (state == TT_TRIPPED);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= TT_ARMED;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= hit;
      case (state)
        TT_ARMED:   if (hit)      state <= TT_TRIPPED;
        TT_TRIPPED: if (soft_off) state <= TT_ARMED;
        default:                  state <= TT_ARMED;
      endcase
    end
  end

  // R2
  reset_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!plat_rst_n && !tripped) |=> !tripped);
  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tripped && !soft_off) |=> tripped);
  // R7
  soft_off_release_chk: assert property (@(posedge clk) disable iff (rst)
    (tripped && soft_off) |=> !tripped);
endmodule

// File: rtl/tt_status.sv
module tt_status (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic hold,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)              flag <= 1'b0;
    else if (set)         flag <= 1'b1;
    else if (clr && !hold) flag <= 1'b0;
  end

  // R9
  clr_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && hold) |=> flag);
endmodule

// File: rtl/thermtrip_guard.sv
module thermtrip_guard #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trip_n,
  input  logic plat_rst_n,
  input  logic soft_off_done,
  input  logic status_clr,
  output logic sleep_l1_n,
  output logic sleep_l2_n,
  output logic sleep_l3_n,
  output logic trip_flag,
  output logic off_req
);
  logic trip_n_s;
  logic tripped;
  logic hit;

  tt_sync #(.STAGES(SYNC_STAGES), .RST_LEVEL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(trip_n), .q(trip_n_s)
  );

  tt_trip_latch u_latch (
    .clk(clk), .rst(rst), .plat_rst_n(plat_rst_n), .trip_act(!trip_n_s),
    .soft_off(soft_off_done), .tripped(tripped), .hit(hit),
    .start_pulse(off_req)
  );

  tt_status u_status (
    .clk(clk), .rst(rst), .set(hit), .clr(status_clr), .hold(tripped),
    .flag(trip_flag)
  );

  assign sleep_l1_n = !tripped;
  assign sleep_l2_n = !tripped;
  assign sleep_l3_n = !tripped;

  // R4
  req_single_chk: assert property (@(posedge clk) disable iff (rst)
    off_req |=> !off_req);
  // R5
  flag_with_lines_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep_l1_n) |-> (trip_flag && off_req));
endmodule

// File: tb/tb_thermtrip_guard.sv
module tb_thermtrip_guard;
  logic clk = 1'b0;
  logic rst, trip_n, plat_rst_n, soft_off_done, status_clr;
  logic sleep_l1_n, sleep_l2_n, sleep_l3_n, trip_flag, off_req;
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  thermtrip_guard dut (
    .clk(clk), .rst(rst), .trip_n(trip_n), .plat_rst_n(plat_rst_n),
    .soft_off_done(soft_off_done), .status_clr(status_clr),
    .sleep_l1_n(sleep_l1_n), .sleep_l2_n(sleep_l2_n), .sleep_l3_n(sleep_l3_n),
    .trip_flag(trip_flag), .off_req(off_req)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] lines();
    return {sleep_l1_n, sleep_l2_n, sleep_l3_n};
  endfunction

  task automatic t_reset();
    rst = 1; trip_n = 1; plat_rst_n = 0; soft_off_done = 0; status_clr = 0;
    step(3);
    check("R1 lines", lines(), 3'b111);
    check("R1 flag", trip_flag, 0);
    check("R1 req", off_req, 0);
    rst = 0;
    step(1);
    check("R1 lines after release", lines(), 3'b111);
  endtask

  task automatic t_ignore_in_reset();
    plat_rst_n = 0; trip_n = 0;
    step(6);
    check("R2 lines", lines(), 3'b111);
    check("R2 flag", trip_flag, 0);
    check("R2 req", off_req, 0);
    trip_n = 1;
    step(3);
    plat_rst_n = 1;
    step(1);
    check("R2 no late trip", lines(), 3'b111);
  endtask

  task automatic t_trip_and_release();
    trip_n = 0;
    step(1);
    check("R3 edge1", lines(), 3'b111);
    step(1);
    check("R3 edge2", lines(), 3'b111);
    step(1);
    check("R3 edge3", lines(), 3'b000);
    check("R4 req pulse", off_req, 1);
    check("R5 flag", trip_flag, 1);
    step(1);
    check("R4 req ends", off_req, 0);
    trip_n = 1;
    step(5);
    check("R6 hold", lines(), 3'b000);
    status_clr = 1;
    step(1);
    status_clr = 0;
    check("R9 clr ignored", trip_flag, 1);
    soft_off_done = 1;
    step(1);
    soft_off_done = 0;
    check("R7 release", lines(), 3'b111);
    check("R7 flag kept", trip_flag, 1);
    status_clr = 1;
    step(1);
    status_clr = 0;
    check("R9 clr works", trip_flag, 0);
  endtask

  task automatic t_rearm_ignore();
    plat_rst_n = 0; trip_n = 0;
    step(5);
    check("R7 ignored after soft-off", lines(), 3'b111);
    trip_n = 1;
    step(3);
    plat_rst_n = 1;
    step(1);
  endtask

  task automatic t_short_pulse_hold();
    trip_n = 0;
    step(1);
    trip_n = 1;
    step(2);
    check("R11 short pulse latches", lines(), 3'b000);
    step(200);
    check("R8 holds", lines(), 3'b000);
    check("R8 flag holds", trip_flag, 1);
    rst = 1;
    step(1);
    rst = 0;
    check("R8 rst clears lines", lines(), 3'b111);
    check("R8 rst clears flag", trip_flag, 0);
    step(1);
  endtask

  task automatic t_set_beats_clear();
    trip_n = 0;
    step(2);
    status_clr = 1;
    step(1);
    status_clr = 0;
    check("R9 set wins lines", lines(), 3'b000);
    check("R9 set wins flag", trip_flag, 1);
    trip_n = 1;
    step(3);
    soft_off_done = 1;
    step(1);
    soft_off_done = 0;
    check("R7 released", lines(), 3'b111);
  endtask

  task automatic t_idle_soft_off();
    soft_off_done = 1;
    step(1);
    soft_off_done = 0;
    check("R10 lines", lines(), 3'b111);
    check("R10 req", off_req, 0);
    check("R10 flag", trip_flag, 1);
    step(1);
    check("R10 lines later", lines(), 3'b111);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_ignore_in_reset();
    t_trip_and_release();
    t_rearm_ignore();
    t_short_pulse_hold();
    t_set_beats_clear();
    t_idle_soft_off();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule